// File: doc/BRIEF.md
# CAN receive timestamp capture strobe

This block produces the strobe that a timer capture channel latches to timestamp received CAN frames. The receive protocol engine reports three things: the start of each frame, any error detected while the frame is on the bus, and the completion of the last end-of-frame bit. The engine reports completion together with the bit-time tick that closes that bit. When a frame completes without any error, the block raises its output on the next system clock. It holds the output high for exactly one bit time and drops it on the following bit-time tick.

A single enable input selects what the capture channel sees. When the enable is set, the channel receives only the frame strobe and the external capture pin is ignored. When the enable is clear, no strobe is made. The pin then reaches the channel through a single register stage. All inputs are single-cycle control levels or pulses in the system clock domain. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. The protocol engine and the timer counter are outside the block.

Top module: `can_rx_stamp_strobe`

## Requirements
- R1: With `stamp_en` high, a cycle with `bit_tick`=1 and `eof_done`=1 for a frame with no recorded error drives `cap_in` high from the first clock edge after that cycle.
- R2: Once high, the strobe stays high until the clock edge at which the next `bit_tick` is seen, and then falls. Its width in clocks equals the bit-tick spacing.
- R3: An `err_flag` pulse at any cycle of a frame, including the cycle of the final end-of-frame tick, prevents the strobe for that frame.
- R4: The recorded error is cleared by `sof` and by frame completion. If `err_flag` and `sof` fall in the same cycle, the error belongs to the new frame.
- R5: With `stamp_en` low, no strobe is produced, and `cap_in` equals the value `cap_pin` had at the previous clock edge.
- R6: With `stamp_en` high, `cap_pin` has no effect on `cap_in`.
- R7: If a valid frame completes on the same tick that would end a running strobe, the strobe stays high for a further full bit time.
- R8: While `rst_n` is low, `cap_in` is 0 and the error record is clear.
- R9: Dropping `stamp_en` cancels any running strobe, so re-enabling before the next tick shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking the end of each nominal bit time |
| eof_done | input | 1 | Last end-of-frame bit completes (qualified by `bit_tick`) |
| err_flag | input | 1 | Protocol error detected in the current frame |
| sof | input | 1 | Start of a new frame |
| stamp_en | input | 1 | Timestamp enable; selects the strobe as capture source |
| cap_pin | input | 1 | External capture pin |
| cap_in | output | 1 | Input to the timer capture channel |

## Verification
Two events can share a clock cycle. First, an error report can arrive on the very tick that completes end-of-frame, where it must win over validation. Second, a new frame can complete on the tick that ends the previous strobe, where the strobe must be renewed. The bench drives each of these on purpose: an error placed on the last sample of the end-of-frame bit, and two completions on consecutive ticks. A behavioural model predicts `cap_in` for every clock, so a missing, early or shortened strobe shows as a mismatch in the cycle where it occurs. An error that sets and a `sof` that clears in the same cycle are also provoked, and the following frame must then yield no strobe.

// File: rtl/can_stamp_pkg.sv
package can_stamp_pkg;
  typedef enum logic {
    CAP_SRC_PIN   = 1'b0,
    CAP_SRC_STAMP = 1'b1
  } cap_src_e;
endpackage

// File: rtl/frame_err_tracker.sv
module frame_err_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic err_flag,
  input  logic sof,
  input  logic frame_end,
  output logic err_seen
);
  // A new error always wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 err_seen <= 1'b0;
    else if (err_flag)          err_seen <= 1'b1;
    else if (sof || frame_end)  err_seen <= 1'b0;
  end
endmodule

// File: rtl/stamp_pulse_gen.sv
module stamp_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic frame_ok,
  input  logic stamp_en,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pulse <= 1'b0;
    else if (!stamp_en) pulse <= 1'b0;
    else if (frame_ok)  pulse <= 1'b1;
    else if (bit_tick)  pulse <= 1'b0;
  end
endmodule

// File: rtl/cap_src_mux.sv
module cap_src_mux
  import can_stamp_pkg::*;
#(
  parameter logic PIN_RST_VAL = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cap_pin,
  input  logic     pulse,
  input  cap_src_e sel,
  output logic     cap_in
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= PIN_RST_VAL;
    else        pin_q <= cap_pin;
  end

  always_comb begin
    unique case (sel)
      CAP_SRC_STAMP: cap_in = pulse;
      default:       cap_in = pin_q;
    endcase
  end
endmodule

// File: rtl/can_rx_stamp_strobe.sv
module can_rx_stamp_strobe
  import can_stamp_pkg::*;
#(
  parameter logic PIN_RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic eof_done,
  input  logic err_flag,
  input  logic sof,
  input  logic stamp_en,
  input  logic cap_pin,
  output logic cap_in
);
  logic     frame_end_w;
  logic     frame_ok_w;
  logic     err_seen_w;
  logic     pulse_w;
  cap_src_e src_w;

  assign frame_end_w = bit_tick & eof_done;
  assign frame_ok_w  = frame_end_w & ~err_seen_w & ~err_flag;
  assign src_w       = stamp_en ? CAP_SRC_STAMP : CAP_SRC_PIN;

  frame_err_tracker u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_flag  (err_flag),
    .sof       (sof),
    .frame_end (frame_end_w),
    .err_seen  (err_seen_w)
  );

  stamp_pulse_gen u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .frame_ok (frame_ok_w),
    .stamp_en (stamp_en),
    .pulse    (pulse_w)
  );

  cap_src_mux #(.PIN_RST_VAL(PIN_RST_VAL)) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_pin (cap_pin),
    .pulse   (pulse_w),
    .sel     (src_w),
    .cap_in  (cap_in)
  );
endmodule

// File: rtl/can_stamp_checker.sv
module can_stamp_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic eof_done,
  input logic err_flag,
  input logic stamp_en,
  input logic cap_pin,
  input logic pulse,
  input logic cap_in
);
  // R1: a rising strobe is always caused by an enabled frame completion
  a_r1_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(bit_tick && eof_done && stamp_en));

  // R2: strobe ends on the next tick that is not a new completion
  a_r2_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && bit_tick && !eof_done) |=> !pulse);

  // R2: strobe holds between ticks while enabled
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !bit_tick && stamp_en) |=> pulse);

  // R3: error on the completing tick suppresses the strobe
  a_r3_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && eof_done && err_flag) |=> !pulse);

  // R5: disabled channel follows the pin with one clock of delay
  a_r5_pin_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!stamp_en && $past(rst_n)) |-> (cap_in == $past(cap_pin)));

  // R9: disabling clears the strobe state
  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    !stamp_en |=> !pulse);
endmodule

bind can_rx_stamp_strobe can_stamp_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_tick (bit_tick),
  .eof_done (eof_done),
  .err_flag (err_flag),
  .stamp_en (stamp_en),
  .cap_pin  (cap_pin),
  .pulse    (pulse_w),
  .cap_in   (cap_in)
);

// File: tb/can_rx_stamp_strobe_bench.sv
module can_rx_stamp_strobe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, eof_done = 1'b0, err_flag = 1'b0, sof = 1'b0;
  logic stamp_en = 1'b0, cap_pin = 1'b0;
  logic cap_in;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    hi_cnt = 0;
  bit    done = 0;
  string cur_req = "R8";

  // behavioural reference state
  bit m_bad = 0, m_pulse = 0, m_pin = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_stamp_strobe u_can_rx_stamp_strobe (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .eof_done(eof_done),
    .err_flag(err_flag), .sof(sof), .stamp_en(stamp_en), .cap_pin(cap_pin),
    .cap_in(cap_in)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bad = 0; m_pulse = 0; m_pin = 0;
    end else begin
      bit fin, good;
      fin  = bit_tick && eof_done;
      good = fin && !m_bad && !err_flag;
      m_pin = cap_pin;
      if (!stamp_en)     m_pulse = 0;
      else if (good)     m_pulse = 1;
      else if (bit_tick) m_pulse = 0;
      if (err_flag)          m_bad = 1;
      else if (sof || fin)   m_bad = 0;
    end
  end

  function automatic bit model_out();
    return stamp_en ? m_pulse : m_pin;
  endfunction

  task automatic check(input bit exp, input string tag);
    n_cmp++;
    if (cap_in !== exp) begin
      n_bad++;
      $display("FAIL %s: cap_in=%0b expected=%0b at %0t", tag, cap_in, exp, $time);
    end
  endtask

  // compare the settled output, then drive the next input set
  task automatic step(input bit tk, input bit eof, input bit err, input bit sf);
    @(negedge clk);
    check(model_out(), cur_req);
    if (cap_in === 1'b1) hi_cnt++;
    bit_tick = tk; eof_done = eof; err_flag = err; sof = sf;
    cap_pin  = 1'($urandom_range(0, 1));
  endtask

  // one nominal bit; err_pos < 0 means no error
  task automatic bit_time(input bit eof, input int err_pos, input bit sf);
    for (int k = 0; k < TICK_DIV; k++)
      step(k == TICK_DIV-1, eof && (k == TICK_DIV-1), err_pos == k, sf && k == 0);
  endtask

  task automatic frame(input int err_bit, input int err_pos);
    bit_time(0, (err_bit == 0) ? err_pos : -1, 1);
    for (int b = 1; b < 3; b++) bit_time(0, (err_bit == b) ? err_pos : -1, 0);
    bit_time(1, (err_bit == 3) ? err_pos : -1, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R8: reset state
    cur_req = "R8";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); cap_pin = 1'b1; stamp_en = 1'($urandom_range(0, 1));
      check(1'b0, "R8");
    end
    @(negedge clk); rst_n = 1'b1; stamp_en = 1'b0;

    // R5: disabled, pin passes with one stage, frames make no strobe
    cur_req = "R5";
    frame(-1, -1); frame(-1, -1);

    // R1 / R2 / R6: clean frame, pin random
    stamp_en = 1'b1;
    cur_req = "R1";
    bit_time(0, -1, 0);
    hi_cnt = 0;
    frame(-1, -1);
    cur_req = "R6";
    bit_time(0, -1, 0); bit_time(0, -1, 0);
    n_cmp++;
    if (hi_cnt != TICK_DIV) begin
      n_bad++;
      $display("FAIL R2: strobe width=%0d expected=%0d", hi_cnt, TICK_DIV);
    end

    // R3: error mid-frame, then error on the completing tick
    cur_req = "R3";
    hi_cnt = 0;
    frame(1, 2);
    frame(3, TICK_DIV-1);
    bit_time(0, -1, 0);
    n_cmp++;
    if (hi_cnt != 0) begin
      n_bad++;
      $display("FAIL R3: strobe cycles=%0d expected=0", hi_cnt);
    end

    // R4: error in previous idle time cleared by sof, then err with sof
    cur_req = "R4";
    bit_time(0, 1, 0);
    frame(-1, -1);
    bit_time(0, -1, 0);
    hi_cnt = 0;
    frame(0, 0);
    bit_time(0, -1, 0);
    n_cmp++;
    if (hi_cnt != 0) begin
      n_bad++;
      $display("FAIL R4: strobe cycles=%0d expected=0", hi_cnt);
    end

    // R7: completion on the tick that ends the strobe
    cur_req = "R7";
    frame(-1, -1);
    hi_cnt = 0;
    bit_time(1, -1, 0);
    bit_time(0, -1, 0); bit_time(0, -1, 0);
    n_cmp++;
    if (hi_cnt != 2*TICK_DIV) begin
      n_bad++;
      $display("FAIL R7: strobe width=%0d expected=%0d", hi_cnt, 2*TICK_DIV);
    end

    // R9: drop enable mid-strobe, re-enable before the next tick
    cur_req = "R9";
    frame(-1, -1);
    step(0, 0, 0, 0);
    stamp_en = 1'b0;
    step(0, 0, 0, 0);
    stamp_en = 1'b1;
    step(0, 0, 0, 0);
    @(negedge clk);
    check(1'b0, "R9");
    bit_time(0, -1, 0);

    // R5: disable again with random pin
    cur_req = "R5";
    stamp_en = 1'b0;
    frame(-1, -1);
    finish_run();
  end
endmodule